// File: doc/BRIEF.md
# Component Swizzle Mask Generator

This block turns a packed pixel-format word into the byte-lane select map that a copy datapath uses to build each destination pixel. The format word gives the size of one component, the number of source components, the number of destination components, and a 4-bit selector for each destination component. Each selector names a source component, one of two constant registers, or zero fill. The generator expands every selector into one lane code for each byte of the component. It writes these codes one per clock into a 16-entry map of 8-bit entries. At the end it reports the bytes-per-pixel of both surfaces, packed into one code, and the row byte counts for a given pixel count.

A start pulse in the idle state launches a conversion. When format conversion is not requested, the block skips the expansion. It reports one byte per pixel on both sides and a cleared map. The state machine has three states. `ST_IDLE` waits for start. Start with format conversion goes to `ST_EXPAND`, and start without it goes to `ST_REPORT`. `ST_EXPAND` writes one map entry per clock and moves to `ST_REPORT` on the last destination byte. `ST_REPORT` raises done for one cycle and always returns to `ST_IDLE`.

Top module: `swz_mask_gen`

## Requirements
- R1: After reset, busy and done are 0, every map entry is 0, both byte counts are 0, the packed size code is 0 and src_used is 0.
- R2: Format word fields: component size minus 1 sits in bits [17:16], source component count minus 1 in bits [21:20], and destination component count minus 1 in bits [25:24]. The selector for destination component i is bits [4i+3:4i].
- R3: A selector s from 0 to 3 produces lane code s × size + b for byte b of its component.
- R4: Selector 4 produces 0x10 + b, selector 5 produces 0x14 + b, and selectors 6 to 15 produce 0x80.
- R5: The code for byte b of destination component i goes to map entry i × size + b (entry k at lane_map bits [8k+7:8k]). Every entry at or beyond size × destination count is 0, because the map is cleared at each accepted start.
- R6: Source bytes-per-pixel is size × source count, and destination bytes-per-pixel is size × destination count. Each row byte count is its bytes-per-pixel × pixel count. cpp_code is ((dst_bpp − 1) << 8) | (src_bpp − 1).
- R7: src_used is 1 when at least one used selector is below 4. When none is, src_used is 0 and the source byte count is 0.
- R8: With fmt_en low, a start yields an all-zero map, cpp_code 0, src_used 1, and both byte counts equal to the pixel count. done rises in the first cycle after the start edge.
- R9: With fmt_en high, busy is high for size × destination count cycles after the start edge. done is high for exactly one cycle, right after that. The results stay unchanged until the next accepted start.
- R10: A start while busy (in `ST_EXPAND` or `ST_REPORT`) is ignored, and its format word and pixel count have no effect on the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a conversion (accepted in idle only) |
| fmt_en | input | 1 | 1 = expand the format word, 0 = plain byte copy |
| fmt_word | input | 32 | Packed format word |
| pix_count | input | PIX_W | Pixels per row |
| lane_map | output | MAP_DEPTH×8 | Lane-select map, entry k at bits [8k+7:8k] |
| src_bytes | output | PIX_W+4 | Source row byte count |
| dst_bytes | output | PIX_W+4 | Destination row byte count |
| cpp_code | output | 16 | Packed bytes-per-pixel code |
| src_used | output | 1 | A selector refers to a source component |
| busy | output | 1 | Expansion in progress |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
The bench covers several corner cases. The first is the full 16-byte map with four-byte components; an off-by-one in the last-byte test would cut the map short or write past it. The second is a format whose selectors are all constants or zero fill; a design that forgot the gating would report a non-zero source count. The third is a short map that follows a long one; a missing clear would leave stale codes in the tail entries. The last is a second start raised mid-expansion; a design that accepted it would mix two formats in one map.

// File: rtl/swz_pkg.sv
package swz_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EXPAND = 2'd1,
        ST_REPORT = 2'd2
    } swz_state_e;

    localparam int SIZE_LSB  = 16;
    localparam int SRCN_LSB  = 20;
    localparam int DSTN_LSB  = 24;
    localparam int SEL_W     = 4;
    localparam int LANE_W    = 8;
    localparam logic [LANE_W-1:0] CONST0_BASE = 8'h10;
    localparam logic [LANE_W-1:0] CONST1_BASE = 8'h14;
    localparam logic [LANE_W-1:0] ZERO_CODE   = 8'h80;
endpackage

// File: rtl/swz_lane_code.sv
module swz_lane_code
    import swz_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  logic [1:0]        byte_idx,
    input  logic [1:0]        size_m1,
    output logic [LANE_W-1:0] code
);
    logic [LANE_W-1:0] size_w;
    logic [LANE_W-1:0] byte_w;

    always_comb begin
        size_w = LANE_W'(size_m1) + LANE_W'(1);
        byte_w = LANE_W'(byte_idx);
        if (sel < 4'd4) begin
            code = LANE_W'(sel[1:0]) * size_w + byte_w;
        end else if (sel == 4'd4) begin
            code = CONST0_BASE + byte_w;
        end else if (sel == 4'd5) begin
            code = CONST1_BASE + byte_w;
        end else begin
            code = ZERO_CODE;
        end
    end
endmodule

// File: rtl/swz_size_calc.sv
module swz_size_calc
    import swz_pkg::*;
#(
    parameter int PIX_W = 16,
    localparam int CNT_W = PIX_W + 4
) (
    input  logic [1:0]       size_m1,
    input  logic [1:0]       srcn_m1,
    input  logic [1:0]       dstn_m1,
    input  logic [PIX_W-1:0] pix,
    output logic [CNT_W-1:0] src_cnt,
    output logic [CNT_W-1:0] dst_cnt,
    output logic [15:0]      cpp
);
    logic [4:0] src_bpp;
    logic [4:0] dst_bpp;
    logic [4:0] src_bpp_m1;
    logic [4:0] dst_bpp_m1;

    always_comb begin
        src_bpp    = (5'(size_m1) + 5'd1) * (5'(srcn_m1) + 5'd1);
        dst_bpp    = (5'(size_m1) + 5'd1) * (5'(dstn_m1) + 5'd1);
        src_bpp_m1 = src_bpp - 5'd1;
        dst_bpp_m1 = dst_bpp - 5'd1;
        src_cnt    = CNT_W'(src_bpp) * CNT_W'(pix);
        dst_cnt    = CNT_W'(dst_bpp) * CNT_W'(pix);
        cpp        = {3'b000, dst_bpp_m1, 3'b000, src_bpp_m1};
    end
endmodule

// File: rtl/swz_map_store.sv
module swz_map_store
    import swz_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [LANE_W-1:0]       wdata,
    output logic [DEPTH*LANE_W-1:0] map_flat
);
    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        logic [LANE_W-1:0] entry_q;
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                entry_q <= '0;
            end else if (we && (waddr == AW'(k))) begin
                entry_q <= wdata;
            end
        end
        assign map_flat[k*LANE_W +: LANE_W] = entry_q;
    end
endmodule

// File: rtl/swz_mask_gen.sv
module swz_mask_gen
    import swz_pkg::*;
#(
    parameter int PIX_W     = 16,
    parameter int MAP_DEPTH = 16,
    localparam int CNT_W    = PIX_W + 4,
    localparam int MAP_AW   = $clog2(MAP_DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        fmt_en,
    input  logic [31:0]                 fmt_word,
    input  logic [PIX_W-1:0]            pix_count,
    output logic [MAP_DEPTH*LANE_W-1:0] lane_map,
    output logic [CNT_W-1:0]            src_bytes,
    output logic [CNT_W-1:0]            dst_bytes,
    output logic [15:0]                 cpp_code,
    output logic                        src_used,
    output logic                        busy,
    output logic                        done
);
    swz_state_e state_q, state_d;

    logic [31:0]       fmt_q;
    logic [PIX_W-1:0]  pix_q;
    logic [1:0]        comp_q;
    logic [1:0]        byte_q;
    logic [MAP_AW-1:0] idx_q;
    logic              used_acc_q;
    logic [CNT_W-1:0]  src_bytes_q;
    logic [CNT_W-1:0]  dst_bytes_q;
    logic [15:0]       cpp_q;
    logic              src_used_q;

    logic [1:0]        size_m1;
    logic [1:0]        srcn_m1;
    logic [1:0]        dstn_m1;
    logic [SEL_W-1:0]  cur_sel;
    logic              last_byte;
    logic              used_now;
    logic [LANE_W-1:0] cur_code;
    logic              map_clr;
    logic              map_we;
    logic [CNT_W-1:0]  calc_src;
    logic [CNT_W-1:0]  calc_dst;
    logic [15:0]       calc_cpp;

    assign size_m1   = fmt_q[SIZE_LSB +: 2];
    assign srcn_m1   = fmt_q[SRCN_LSB +: 2];
    assign dstn_m1   = fmt_q[DSTN_LSB +: 2];
    assign cur_sel   = fmt_q[comp_q*SEL_W +: SEL_W];
    assign last_byte = (comp_q == dstn_m1) && (byte_q == size_m1);
    assign used_now  = used_acc_q || (cur_sel < 4'd4);
    assign map_clr   = (state_q == ST_IDLE) && start;
    assign map_we    = (state_q == ST_EXPAND);

    swz_lane_code u_code (
        .sel      (cur_sel),
        .byte_idx (byte_q),
        .size_m1  (size_m1),
        .code     (cur_code)
    );

    swz_size_calc #(.PIX_W(PIX_W)) u_size (
        .size_m1 (size_m1),
        .srcn_m1 (srcn_m1),
        .dstn_m1 (dstn_m1),
        .pix     (pix_q),
        .src_cnt (calc_src),
        .dst_cnt (calc_dst),
        .cpp     (calc_cpp)
    );

    swz_map_store #(.DEPTH(MAP_DEPTH)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (map_clr),
        .we       (map_we),
        .waddr    (idx_q),
        .wdata    (cur_code),
        .map_flat (lane_map)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = fmt_en ? ST_EXPAND : ST_REPORT;
            ST_EXPAND: if (last_byte) state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State-decoded outputs
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_EXPAND: busy = 1'b1;
            ST_REPORT: done = 1'b1;
            default: ;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q       <= '0;
            pix_q       <= '0;
            comp_q      <= '0;
            byte_q      <= '0;
            idx_q       <= '0;
            used_acc_q  <= 1'b0;
            src_bytes_q <= '0;
            dst_bytes_q <= '0;
            cpp_q       <= '0;
            src_used_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        fmt_q      <= fmt_word;
                        pix_q      <= pix_count;
                        comp_q     <= '0;
                        byte_q     <= '0;
                        idx_q      <= '0;
                        used_acc_q <= 1'b0;
                        if (!fmt_en) begin
                            src_bytes_q <= CNT_W'(pix_count);
                            dst_bytes_q <= CNT_W'(pix_count);
                            cpp_q       <= '0;
                            src_used_q  <= 1'b1;
                        end
                    end
                end
                ST_EXPAND: begin
                    idx_q <= idx_q + MAP_AW'(1);
                    if (byte_q == 2'd0) begin
                        used_acc_q <= used_now;
                    end
                    if (byte_q == size_m1) begin
                        byte_q <= '0;
                        comp_q <= comp_q + 2'd1;
                    end else begin
                        byte_q <= byte_q + 2'd1;
                    end
                    if (last_byte) begin
                        src_bytes_q <= used_now ? calc_src : '0;
                        dst_bytes_q <= calc_dst;
                        cpp_q       <= calc_cpp;
                        src_used_q  <= used_now;
                    end
                end
                default: ;
            endcase
        end
    end

    assign src_bytes = src_bytes_q;
    assign dst_bytes = dst_bytes_q;
    assign cpp_code  = cpp_q;
    assign src_used  = src_used_q;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R7
    src_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !src_used) |-> (src_bytes == '0));

    // R8
    plain_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(state_q) == ST_IDLE) |-> (cpp_code == 16'd0 && src_bytes == dst_bytes && src_used));

    // R10
    fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXPAND && $past(state_q) == ST_EXPAND) |-> $stable(fmt_q));

    // R5
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXPAND) |-> (5'(idx_q) < (5'(size_m1) + 5'd1) * (5'(dstn_m1) + 5'd1)));
endmodule

// File: tb/test_swz_mask_gen.sv
module test_swz_mask_gen;
    localparam int CLK_PERIOD = 10;
    localparam int PIX_W = 16;
    localparam int DEPTH = 16;
    localparam int CNT_W = PIX_W + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic fmt_en = 1'b0;
    logic [31:0] fmt_word = '0;
    logic [PIX_W-1:0] pix_count = '0;
    logic [DEPTH*8-1:0] lane_map;
    logic [CNT_W-1:0] src_bytes, dst_bytes;
    logic [15:0] cpp_code;
    logic src_used, busy, done;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swz_mask_gen #(.PIX_W(PIX_W), .MAP_DEPTH(DEPTH)) i_swz_mask_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .fmt_en(fmt_en),
        .fmt_word(fmt_word), .pix_count(pix_count), .lane_map(lane_map),
        .src_bytes(src_bytes), .dst_bytes(dst_bytes), .cpp_code(cpp_code),
        .src_used(src_used), .busy(busy), .done(done)
    );

    function automatic int lane_of(int sel, int b, int sz);
        if (sel < 4) return sel * sz + b;
        if (sel == 4) return 16 + b;
        if (sel == 5) return 20 + b;
        return 128;
    endfunction

    function automatic logic [DEPTH*8-1:0] exp_map(logic en, logic [31:0] f);
        logic [DEPTH*8-1:0] m = '0;
        int sz = int'(f[17:16]) + 1;
        int dn = int'(f[25:24]) + 1;
        if (!en) return m;
        for (int i = 0; i < dn; i++)
            for (int b = 0; b < sz; b++)
                m[(i*sz+b)*8 +: 8] = 8'(lane_of(int'(f[i*4 +: 4]), b, sz));
        return m;
    endfunction

    function automatic logic exp_used(logic en, logic [31:0] f);
        int dn = int'(f[25:24]) + 1;
        if (!en) return 1'b1;
        for (int i = 0; i < dn; i++)
            if (f[i*4 +: 4] < 4) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run(logic en, logic [31:0] f, logic [PIX_W-1:0] pix, logic poke);
        int sz = int'(f[17:16]) + 1;
        int sn = int'(f[21:20]) + 1;
        int dn = int'(f[25:24]) + 1;
        int sb = en ? sz * sn : 1;
        int db = en ? sz * dn : 1;
        logic u = exp_used(en, f);
        logic [DEPTH*8-1:0] em = exp_map(en, f);
        int lat = 0;
        int busy_cnt = 0;
        @(negedge clk);
        start = 1'b1; fmt_en = en; fmt_word = f; pix_count = pix;
        @(negedge clk);
        start = 1'b0;
        if (en && poke) begin
            // R10: second start mid-run with a different word and count
            start = 1'b1; fmt_word = ~f; pix_count = ~pix;
        end
        while (!done && lat < 64) begin
            if (busy) busy_cnt++;
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        start = 1'b0;
        check("R9", "latency", lat, en ? sz * dn : 0);
        check("R9", "busy cycles", busy_cnt, en ? sz * dn : 0);
        check("R5", "lane map lo", em[63:0] ^ lane_map[63:0], 0);
        check("R5", "lane map hi", em[127:64] ^ lane_map[127:64], 0);
        check("R6", "dst bytes", dst_bytes, db * int'(pix));
        check("R7", "src bytes", src_bytes, u ? sb * int'(pix) : 0);
        check("R6", "cpp code", cpp_code, en ? ((db - 1) << 8) | (sb - 1) : 0);
        check("R7", "src used", src_used, u);
        @(negedge clk);
        check("R9", "done one cycle", done, 0);
        check("R9", "result hold", dst_bytes, db * int'(pix));
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        failures++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seed = 7;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "busy", busy, 0);
        check("R1", "done", done, 0);
        check("R1", "map", |lane_map, 0);
        check("R1", "counts", src_bytes | dst_bytes, 0);
        check("R1", "cpp", cpp_code, 0);
        check("R1", "src used", src_used, 0);
        rst_n = 1'b1;
        // R3 R2: full 16-byte map, four 4-byte source components reversed
        run(1'b1, 32'h0333_0123, 16'd100, 1'b0);
        // R4 R7: constants and zero fill only, short map after long one
        run(1'b1, 32'h0102_0F54, 16'd9, 1'b0);
        // R4: constant 1 and zero fill with 1-byte components
        run(1'b1, 32'h0300_9845, 16'd1, 1'b0);
        // R3: single byte component copy
        run(1'b1, 32'h0000_0000, 16'hFFFF, 1'b0);
        // R8 plain mode
        run(1'b0, 32'h0333_FFFF, 16'd321, 1'b0);
        // R10 start while busy
        run(1'b1, 32'h0231_0210, 16'd55, 1'b1);
        // R6 random formats
        for (int n = 0; n < 60; n++) begin
            logic [31:0] f = $urandom;
            run(n % 7 != 3, f & 32'h0333_FFFF, 16'($urandom), n % 5 == 0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule